// File: doc/BRIEF.md
# Pre-boot command stream processor

This block walks an initialization image held in serial flash, one 32-bit word at a time, and turns it into register writes ahead of normal boot. The image is a series of frames. Each frame begins with a header word that gives a byte count and a 24-bit target address, and the payload words that follow are issued in order as 32-bit writes on a valid/ready write bus, at addresses that step by 4.

Incoming flash words pass through a byte-lane mapper before they are used. An input chosen at reset sets the initial mapping. A write inside the stream to the flash controller's mode register changes the mapping for every word that follows. A running CRC-32 covers every header and data word as seen after mapping. A terminating CRC command frame carries the expected checksum, and the result is reported on `crc_pass`. A malformed header stops the walk and raises `error`.

Top module: `preboot_cmd_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `done`, `crc_pass`, `error`, `rd_req` and `wr_valid` are all 0.
- R2: A header word has bit 31 = 1 (valid), bits 30:24 = byte count, and bits 23:0 = target address. A count of N bytes produces N/4 writes, in stream order, at the target address plus 0, 4, 8 and so on, with the payload words as data.
- R3: Once `wr_valid` is high it stays high, with `wr_addr` and `wr_data` unchanged, until a cycle with `wr_ready` high.
- R4: A `start` pulse samples `order_strap`. Value 0 (the default) selects byte reversal, so that logical bits 31:24 come from raw bits 7:0 and so on. Value 1 passes raw words through unchanged.
- R5: A write to `MODE_ADDR` (default 0x550000) sets the mapping for every later word from bit `ORD_BIT` (default 0) of its data: 1 selects pass-through and 0 selects byte reversal. The mapping changes at no other time during a run.
- R6: The CRC uses polynomial 0x04C11DB7, initial value 0xFFFFFFFF, no reflection and no final inversion. It is fed MSB first with every mapped header and data word, and the expected-CRC word is not included. `crc_pass` is 1 only if the mapped expected word equals that CRC.
- R7: A header with bit 31 = 1, count 0 and address `CRC_CMD_ADDR` (default 0xFFFFFF) is the CRC command. The next word is the expected CRC, and then `done` rises.
- R8: A header with bit 31 clear, or with a count that is 0 (outside the CRC command), not a multiple of 4, or above 64, sets `done` = 1, `error` = 1 and `crc_pass` = 0. No further reads or writes follow.
- R9: `done`, `crc_pass` and `error` hold their values until the next accepted `start`, and an accepted `start` clears them. A `start` pulse while a run is in progress is ignored.
- R10: At most one of `rd_req` and `wr_valid` is high at any time. `rd_req` stays high until `rd_valid`, and no word is read ahead of a pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk of the image when idle |
| order_strap | input | 1 | Initial byte mapping: 0 reversed, 1 pass-through |
| rd_req | output | 1 | Request for the next flash word |
| rd_valid | input | 1 | Flash word present on rd_data |
| rd_data | input | 32 | Raw flash word |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Target accepts the write |
| wr_addr | output | 24 | Write address |
| wr_data | output | 32 | Write data |
| done | output | 1 | Walk finished, by CRC check or by error |
| crc_pass | output | 1 | Expected CRC matched |
| error | output | 1 | Malformed header stopped the walk |

## Verification
The assertions assume that the flash source raises `rd_valid` only while `rd_req` is high and for a single cycle per word, and that the write target raises `wr_ready` only while `wr_valid` is high. The bench's source and sink models drive from the falling edge and follow these rules. They insert varying wait cycles, and they drop each handshake signal on the edge after it is used. The stimulus sweeps frame lengths over every legal count for both strap values, flips the mapping in the middle of the stream, and feeds each kind of malformed header.

// File: rtl/pbi_pkg.sv
package pbi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_WRITE,
    ST_CRC
  } pbi_state_t;

  // One CRC-32 update over a 32-bit word, MSB first, non-reflected.
  function automatic logic [31:0] crc32_word(input logic [31:0] c_in,
                                             input logic [31:0] w,
                                             input logic [31:0] poly);
    logic [31:0] c;
    c = c_in;
    for (int b = 31; b >= 0; b--) begin
      if (c[31] ^ w[b]) c = {c[30:0], 1'b0} ^ poly;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/pbi_order_map.sv
module pbi_order_map #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              straight,
  output logic [DATA_W-1:0] word
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] rev;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign rev[8*g +: 8] = raw[8*(LANES-1-g) +: 8];
    end
  endgenerate

  assign word = straight ? raw : rev;
endmodule

// File: rtl/pbi_crc_acc.sv
module pbi_crc_acc #(
  parameter logic [31:0] POLY = 32'h04C11DB7,
  parameter logic [31:0] INIT = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [31:0] din,
  output logic [31:0] crc
);
  import pbi_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= INIT;
    else if (en)    crc <= crc32_word(crc, din, POLY);
  end

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(crc)); // R6
endmodule

// File: rtl/preboot_cmd_engine.sv
module preboot_cmd_engine #(
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 24,
  parameter int          CNT_W        = 7,
  parameter int          MAX_BYTES    = 64,
  parameter logic [23:0] MODE_ADDR    = 24'h550000,
  parameter logic [23:0] CRC_CMD_ADDR = 24'hFFFFFF,
  parameter int          ORD_BIT      = 0,
  parameter logic [31:0] CRC_POLY     = 32'h04C11DB7,
  parameter logic [31:0] CRC_INIT     = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              order_strap,
  output logic              rd_req,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done,
  output logic              crc_pass,
  output logic              error
);
  import pbi_pkg::*;

  localparam int CNT_LSB = ADDR_W;
  localparam int VLD_BIT = ADDR_W + CNT_W;
  localparam int WL_W    = $clog2(MAX_BYTES / 4) + 1;

  pbi_state_t        state;
  logic              ord_straight;
  logic [DATA_W-1:0] word;
  logic [31:0]       crc_q;
  logic [WL_W-1:0]   words_left;
  logic              start_acc;

  logic              h_vld;
  logic [CNT_W-1:0]  h_cnt;
  logic [ADDR_W-1:0] h_adr;
  logic              h_crc_cmd;
  logic              h_bad;
  logic              crc_en;
  logic              wr_fire;

  pbi_order_map #(.DATA_W(DATA_W)) i_map (
    .raw     (rd_data),
    .straight(ord_straight),
    .word    (word)
  );

  pbi_crc_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) i_crc (
    .clk(clk),
    .rst(rst),
    .clr(start_acc),
    .en (crc_en),
    .din(word),
    .crc(crc_q)
  );

  assign h_vld     = word[VLD_BIT];
  assign h_cnt     = word[CNT_LSB +: CNT_W];
  assign h_adr     = word[ADDR_W-1:0];
  assign h_crc_cmd = h_vld && (h_cnt == '0) && (h_adr == CRC_CMD_ADDR);
  assign h_bad     = !h_vld || (h_cnt == '0) || (h_cnt[1:0] != 2'b00) ||
                     (int'(h_cnt) > MAX_BYTES);

  assign start_acc = start && (state == ST_IDLE);
  assign crc_en    = rd_valid && ((state == ST_HDR) || (state == ST_DATA));
  assign wr_fire   = (state == ST_WRITE) && wr_ready;
  assign rd_req    = (state == ST_HDR) || (state == ST_DATA) || (state == ST_CRC);
  assign wr_valid  = (state == ST_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ord_straight <= 1'b0;
      words_left   <= '0;
      wr_addr      <= '0;
      wr_data      <= '0;
      done         <= 1'b0;
      crc_pass     <= 1'b0;
      error        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            ord_straight <= order_strap;
            done         <= 1'b0;
            crc_pass     <= 1'b0;
            error        <= 1'b0;
            state        <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (rd_valid) begin
            if (h_crc_cmd) begin
              state <= ST_CRC;
            end else if (h_bad) begin
              done  <= 1'b1;
              error <= 1'b1;
              state <= ST_IDLE;
            end else begin
              words_left <= WL_W'(h_cnt >> 2);
              wr_addr    <= h_adr;
              state      <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (rd_valid) begin
            wr_data <= word;
            state   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            if (wr_addr == MODE_ADDR) ord_straight <= wr_data[ORD_BIT];
            wr_addr    <= wr_addr + ADDR_W'(4);
            words_left <= words_left - 1'b1;
            state      <= (words_left == WL_W'(1)) ? ST_HDR : ST_DATA;
          end
        end
        ST_CRC: begin
          if (rd_valid) begin
            crc_pass <= (word == crc_q);
            done     <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R3

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_valid)); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> rd_req); // R10

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(crc_pass) && $stable(error))); // R9

  AST_ERR_NO_PASS: assert property (@(posedge clk) disable iff (rst)
    error |-> (done && !crc_pass)); // R8

  AST_ORDER_SRC: assert property (@(posedge clk) disable iff (rst)
    !$stable(ord_straight) |->
      ($past(start_acc) || $past(wr_valid && wr_ready && (wr_addr == MODE_ADDR)))); // R5

  AST_WORDS_LEFT: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (words_left != '0)); // R2
endmodule

// File: tb/test_preboot_cmd_engine.sv
module test_preboot_cmd_engine;

  localparam logic [23:0] MODE_A = 24'h550000;
  localparam logic [23:0] CRC_A  = 24'hFFFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        order_strap = 1'b0;
  logic        rd_req;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [23:0] wr_addr;
  logic [31:0] wr_data;
  logic        done, crc_pass, error;

  always #2 clk = ~clk;

  preboot_cmd_engine i_preboot_cmd_engine (
    .clk(clk), .rst(rst), .start(start), .order_strap(order_strap),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .crc_pass(crc_pass), .error(error)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  logic [31:0] raw_q [0:255];
  int          raw_n;
  logic [23:0] exp_a [0:127];
  logic [31:0] exp_d [0:127];
  int          exp_n;
  logic [23:0] got_a [0:127];
  logic [31:0] got_d [0:127];
  int          got_n;
  int          rd_idx;
  int          lat;
  int          stall;
  logic        cur_ord;
  logic [31:0] run_crc;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Byte-serial CRC-32, MSB first, poly 0x04C11DB7
  function automatic logic [31:0] crc_bytes(input logic [31:0] c_in, input logic [31:0] w);
    logic [31:0] c;
    logic [7:0]  by;
    c = c_in;
    for (int k = 3; k >= 0; k--) begin
      by = w[8*k +: 8];
      c = c ^ {by, 24'h0};
      for (int j = 0; j < 8; j++)
        c = c[31] ? ({c[30:0], 1'b0} ^ 32'h04C11DB7) : {c[30:0], 1'b0};
    end
    return c;
  endfunction

  task automatic t_begin(input logic strap);
    raw_n = 0; exp_n = 0;
    cur_ord = strap;
    order_strap = strap;
    run_crc = 32'hFFFFFFFF;
  endtask

  task automatic push(input logic [31:0] lw, input bit in_crc);
    raw_q[raw_n] = cur_ord ? lw : bswap(lw);
    raw_n++;
    if (in_crc) run_crc = crc_bytes(run_crc, lw);
  endtask

  task automatic add_frame(input logic [23:0] a, input int nw, input int seed);
    logic [31:0] d;
    push({1'b1, 7'(nw * 4), a}, 1'b1);
    for (int i = 0; i < nw; i++) begin
      d = {8'(seed), 8'(i), 8'(~seed), 8'(i * 7 + 3)};
      push(d, 1'b1);
      exp_a[exp_n] = a + 24'(4 * i);
      exp_d[exp_n] = d;
      exp_n++;
      if (a + 24'(4 * i) == MODE_A) cur_ord = d[0];
    end
  endtask

  task automatic add_mode(input logic straight_next);
    logic [31:0] d;
    d = {31'h1234_567 << 3, straight_next};
    push({1'b1, 7'd4, MODE_A}, 1'b1);
    push(d, 1'b1);
    exp_a[exp_n] = MODE_A; exp_d[exp_n] = d; exp_n++;
    cur_ord = straight_next;
  endtask

  task automatic add_crc(input bit corrupt);
    push({1'b1, 7'd0, CRC_A}, 1'b1);
    push(corrupt ? (run_crc ^ 32'h1) : run_crc, 1'b0);
  endtask

  // Source model: one word per rd_req, varying latency
  always @(negedge clk) begin
    if (rd_valid) rd_valid = 1'b0;
    else if (rd_req) begin
      if (lat == 0) begin
        rd_data  = (rd_idx < raw_n) ? raw_q[rd_idx] : 32'h0;
        rd_idx   = rd_idx + 1;
        rd_valid = 1'b1;
        lat      = rd_idx % 3;
      end else lat = lat - 1;
    end
  end

  // Sink model: logs writes, inserts stalls
  always @(negedge clk) begin
    if (wr_ready) wr_ready = 1'b0;
    else if (wr_valid) begin
      if (stall == 0) begin
        if (got_n < 128) begin
          got_a[got_n] = wr_addr;
          got_d[got_n] = wr_data;
        end
        got_n    = got_n + 1;
        wr_ready = 1'b1;
        stall    = got_n % 2;
      end else stall = stall - 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run(input bit exp_pass, input bit exp_err, input string req,
                     input bit poke_busy);
    int t;
    logic p0, e0;
    rd_idx = 0; got_n = 0; lat = 0; stall = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R9 start clears done", done, 0);
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, {req, " done"}, done, 1);
    chk(error == exp_err, {req, " error"}, error, exp_err);
    chk(crc_pass == exp_pass, {req, " crc_pass"}, crc_pass, exp_pass);
    chk(got_n == exp_n, {req, " write count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_a[i] == exp_a[i], "R2 write addr", got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], "R2 write data", got_d[i], exp_d[i]);
    end
    p0 = crc_pass; e0 = error;
    repeat (8) @(negedge clk);
    chk(rd_idx == raw_n, {req, " reads used"}, rd_idx, raw_n);
    chk(done && crc_pass == p0 && error == e0 && !rd_req && !wr_valid,
        "R9 result held", {done, crc_pass, error}, {1'b1, p0, e0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !crc_pass && !error && !rd_req && !wr_valid, "R1 reset",
        {done, crc_pass, error, rd_req, wr_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !crc_pass && !error && !rd_req && !wr_valid, "R1 after reset",
        {done, crc_pass, error, rd_req, wr_valid}, 0);

    // R2 R4 R5 R6 R7: sweep all legal counts, both straps, mid-stream order flip
    for (int s = 0; s < 2; s++) begin
      for (int n = 1; n <= 16; n++) begin
        t_begin(1'(s));
        add_frame(24'hEE0100, 16, n);
        add_frame(24'h570000 + 24'(n * 256), n, n + 40);
        add_mode(~1'(s));
        add_frame(24'h400000 + 24'(n * 16), 17 - n, n + 90);
        add_crc(1'b0);
        run(1'b1, 1'b0, "R6 R7 sweep", n == 5);
      end
    end

    // R6: corrupted expected value
    t_begin(1'b0);
    add_frame(24'h001000, 3, 7);
    add_crc(1'b1);
    run(1'b0, 1'b0, "R6 bad crc", 1'b0);

    // R5: flip twice, repeated writes to one address
    t_begin(1'b1);
    add_mode(1'b0);
    add_frame(24'h001000, 1, 8);
    add_frame(24'h001000, 1, 9);
    add_mode(1'b1);
    add_frame(24'h002000, 2, 10);
    add_crc(1'b0);
    run(1'b1, 1'b0, "R5 double flip", 1'b0);

    // R8: malformed headers
    t_begin(1'b0); add_frame(24'h000100, 2, 1);
    push({1'b1, 7'd6, 24'h000200}, 1'b1);
    run(1'b0, 1'b1, "R8 count not multiple of 4", 1'b0);

    t_begin(1'b0); add_frame(24'h000100, 2, 2);
    push({1'b1, 7'd68, 24'h000200}, 1'b1);
    run(1'b0, 1'b1, "R8 count above 64", 1'b0);

    t_begin(1'b1); add_frame(24'h000100, 1, 3);
    push({1'b1, 7'd0, 24'h000010}, 1'b1);
    run(1'b0, 1'b1, "R8 zero count", 1'b0);

    t_begin(1'b1);
    push({1'b0, 7'd8, 24'h000300}, 1'b1);
    run(1'b0, 1'b1, "R8 valid bit clear", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule